// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block takes one 32-bit virtual address per request. It sorts the address into one of five fixed segments by its top three bits. The segment is then checked against the privilege level in effect.

There are two outcomes for a legal access:

- **Direct windows.** The two direct-mapped kernel windows return a physical address at once. Each also returns a cacheability attribute.
- **Mapped segments.** The three mapped segments raise a flag. This tells the surrounding pipeline to send the request to a separate translation unit.

An access that the current privilege does not allow becomes an address-error fault. The fault code tells a load or instruction fetch apart from a store.

All results leave a single register stage. Each result appears exactly one clock after its request, so the block can sit inside an address-generation stage.

Top module: `vseg_decode`

## Requirements
- R1: `rsp_valid` equals `req_valid` from the previous clock. While `rsp_valid` is low, every other output is zero.
- R2: Addresses 0x00000000..0x7FFFFFFF give segment code 0 with `rsp_mapped`=1 in every privilege level.
- R3: Addresses 0x80000000..0x9FFFFFFF give segment code 1. For a kernel access, `rsp_paddr` = address − 0x80000000, `rsp_cached`=1 and `rsp_mapped`=0.
- R4: Addresses 0xA0000000..0xBFFFFFFF give segment code 2. For a kernel access, `rsp_paddr` = address − 0xA0000000, `rsp_cached`=0 and `rsp_mapped`=0.
- R5: Addresses 0xC0000000..0xDFFFFFFF give segment code 3. They are mapped, and allowed in kernel and supervisor levels only.
- R6: Addresses 0xE0000000..0xFFFFFFFF give segment code 4. They are mapped, and allowed in kernel level only.
- R7: `req_mode` 2'b00 selects kernel, 2'b01 selects supervisor, and 2'b10 or 2'b11 selects user.
- R8: When `req_exl` or `req_erl` is high, the access is checked as kernel, whatever `req_mode` holds.
- R9: A disallowed access sets `rsp_fault`=1 and `rsp_exc_code`=4 for a load or fetch (`req_store`=0), or 5 for a store. In that case `rsp_mapped`, `rsp_cached` and `rsp_paddr` are zero. A permitted access has `rsp_exc_code`=0.
- R10: A mapped response carries `rsp_paddr`=0 and `rsp_cached`=0.
- R11: Synchronous reset clears every output, including after traffic has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load or fetch |
| req_mode | input | 2 | Privilege field (00 kernel, 01 supervisor, 10/11 user) |
| req_exl | input | 1 | Exception level active |
| req_erl | input | 1 | Error level active |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address for direct windows |
| rsp_seg | output | 3 | Segment code 0..4 |
| rsp_mapped | output | 1 | Needs translation |
| rsp_cached | output | 1 | Cacheable direct access |
| rsp_fault | output | 1 | Address-error fault |
| rsp_exc_code | output | 5 | Fault code (4 load, 5 store, 0 none) |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 5-bit fault code.

With these values the bench can reach both edges of every segment, all four privilege encodings, and the level overrides. It covers every pairing of segment and privilege, plus random addresses. It also holds gaps in `req_valid` to check that idle outputs are zero.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  typedef enum logic [2:0] {
    SEG_USER  = 3'd0,
    SEG_KDIR  = 3'd1,
    SEG_KUNC  = 3'd2,
    SEG_SUPM  = 3'd3,
    SEG_KMAP  = 3'd4
  } seg_e;

  localparam int NUM_SEG = 5;

  typedef enum logic [1:0] {
    PRIV_KERN = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_USER = 2'd2
  } priv_e;

  // Permission table: bit p set when privilege p may enter the segment.
  function automatic logic [2:0] seg_allow(input int s);
    case (s)
      0:       return 3'b111;
      3:       return 3'b011;
      default: return 3'b001;
    endcase
  endfunction
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int OFF_W = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] vaddr,
  output seg_e              seg,
  output logic [OFF_W-1:0]  win_off,
  output logic              direct,
  output logic              cacheable
);
  logic [2:0] top;
  assign top     = vaddr[ADDR_W-1 -: 3];
  assign win_off = vaddr[OFF_W-1:0];

  always_comb begin
    seg       = SEG_USER;
    direct    = 1'b0;
    cacheable = 1'b0;
    case (top)
      3'b100: begin seg = SEG_KDIR; direct = 1'b1; cacheable = 1'b1; end
      3'b101: begin seg = SEG_KUNC; direct = 1'b1; end
      3'b110: seg = SEG_SUPM;
      3'b111: seg = SEG_KMAP;
      default: seg = SEG_USER;
    endcase
  end
endmodule

// File: rtl/vseg_priv.sv
module vseg_priv
  import vseg_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       exl,
  input  logic       erl,
  output priv_e      priv
);
  always_comb begin
    if (exl || erl)          priv = PRIV_KERN;
    else if (mode == 2'b00)  priv = PRIV_KERN;
    else if (mode == 2'b01)  priv = PRIV_SUP;
    else                     priv = PRIV_USER;
  end
endmodule

// File: rtl/vseg_access.sv
module vseg_access
  import vseg_pkg::*;
(
  input  seg_e  seg,
  input  priv_e priv,
  output logic  allowed
);
  logic [NUM_SEG-1:0] hit;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [2:0] ALLOW = seg_allow(s);
    assign hit[s] = (seg == seg_e'(s)) && ALLOW[priv];
  end

  assign allowed = |hit;
endmodule

// File: rtl/vseg_decode.sv
module vseg_decode
  import vseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int EXC_W = 5,
  parameter int LOAD_CODE = 4,
  parameter int STORE_CODE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_store,
  input  logic [1:0]        req_mode,
  input  logic              req_exl,
  input  logic              req_erl,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [2:0]        rsp_seg,
  output logic              rsp_mapped,
  output logic              rsp_cached,
  output logic              rsp_fault,
  output logic [EXC_W-1:0]  rsp_exc_code
);
  localparam int OFF_W = ADDR_W - 3;

  seg_e             seg;
  logic [OFF_W-1:0] win_off;
  logic             direct, cacheable, allowed;
  priv_e            priv;

  vseg_classify #(.ADDR_W(ADDR_W)) u_cls (
    .vaddr(req_vaddr), .seg(seg), .win_off(win_off),
    .direct(direct), .cacheable(cacheable)
  );

  vseg_priv u_priv (
    .mode(req_mode), .exl(req_exl), .erl(req_erl), .priv(priv)
  );

  vseg_access u_acc (.seg(seg), .priv(priv), .allowed(allowed));

  logic              n_fault, n_mapped, n_cached;
  logic [ADDR_W-1:0] n_paddr;
  logic [EXC_W-1:0]  n_code;

  always_comb begin
    n_fault  = req_valid && !allowed;
    n_mapped = req_valid && allowed && !direct;
    n_cached = req_valid && allowed && direct && cacheable;
    n_paddr  = '0;
    n_code   = '0;
    if (req_valid && allowed && direct) n_paddr = {3'b000, win_off};
    if (n_fault) n_code = req_store ? EXC_W'(STORE_CODE) : EXC_W'(LOAD_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_seg      <= '0;
      rsp_mapped   <= 1'b0;
      rsp_cached   <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_exc_code <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_paddr    <= n_paddr;
      rsp_seg      <= req_valid ? seg : 3'd0;
      rsp_mapped   <= n_mapped;
      rsp_cached   <= n_cached;
      rsp_fault    <= n_fault;
      rsp_exc_code <= n_code;
    end
  end
endmodule

// File: rtl/vseg_decode_chk.sv
module vseg_decode_chk #(
  parameter int ADDR_W = 32,
  parameter int EXC_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_store,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [2:0]        rsp_seg,
  input logic              rsp_mapped,
  input logic              rsp_cached,
  input logic              rsp_fault,
  input logic [EXC_W-1:0]  rsp_exc_code
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rsp_valid == $past(req_valid));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_paddr == '0 && rsp_seg == 3'd0 && !rsp_mapped &&
                    !rsp_cached && !rsp_fault && rsp_exc_code == '0));

  // R9
  fault_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_fault) |-> rsp_exc_code == ($past(req_store) ? EXC_W'(5) : EXC_W'(4)));

  // R9
  fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (!rsp_mapped && !rsp_cached && rsp_paddr == '0));

  // R9
  nofault_code_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_fault |-> rsp_exc_code == '0);

  // R2
  user_open_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_seg == 3'd0) |-> (!rsp_fault && rsp_mapped));

  // R10
  mapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_mapped |-> (rsp_paddr == '0 && !rsp_cached));

  // R3
  cached_window_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_cached |-> rsp_seg == 3'd1);
endmodule

bind vseg_decode vseg_decode_chk #(.ADDR_W(ADDR_W), .EXC_W(EXC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_seg(rsp_seg),
  .rsp_mapped(rsp_mapped), .rsp_cached(rsp_cached), .rsp_fault(rsp_fault),
  .rsp_exc_code(rsp_exc_code)
);

// File: tb/sim_vseg_decode.sv
`timescale 1ns/1ps
module sim_vseg_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic [1:0]  req_mode = 2'b00;
  logic        req_exl = 1'b0;
  logic        req_erl = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_seg;
  logic        rsp_mapped, rsp_cached, rsp_fault;
  logic [4:0]  rsp_exc_code;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vseg_decode u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_store(req_store), .req_mode(req_mode), .req_exl(req_exl),
    .req_erl(req_erl), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_seg(rsp_seg), .rsp_mapped(rsp_mapped), .rsp_cached(rsp_cached),
    .rsp_fault(rsp_fault), .rsp_exc_code(rsp_exc_code)
  );

  // Packed view: valid, paddr, seg, mapped, cached, fault, code
  typedef logic [43:0] resp_t;
  resp_t exp_q = '0;
  string exp_tag = "R11";

  function automatic resp_t model(input logic v, input logic [31:0] a,
                                  input logic st, input logic [1:0] m,
                                  input logic x, input logic e);
    int lvl, seg;
    logic ok, dir, mp, ca, fl;
    logic [31:0] pa;
    logic [4:0] cd;
    if (!v) return '0;
    lvl = (x || e) ? 0 : (m == 2'b00 ? 0 : (m == 2'b01 ? 1 : 2));
    if (a < 32'h8000_0000)      seg = 0;
    else if (a < 32'hA000_0000) seg = 1;
    else if (a < 32'hC000_0000) seg = 2;
    else if (a < 32'hE000_0000) seg = 3;
    else                        seg = 4;
    ok  = (seg == 0) || (seg == 3 && lvl <= 1) || lvl == 0;
    dir = (seg == 1 || seg == 2);
    fl  = !ok;
    mp  = ok && !dir;
    ca  = ok && seg == 1;
    pa  = 32'h0;
    if (ok && seg == 1) pa = a - 32'h8000_0000;
    if (ok && seg == 2) pa = a - 32'hA000_0000;
    cd  = fl ? (st ? 5'd5 : 5'd4) : 5'd0;
    return {1'b1, pa, 3'(seg), mp, ca, fl, cd};
  endfunction

  function automatic string tag_of(input resp_t r, input logic [1:0] m,
                                   input logic x, input logic e);
    if (!r[43])               return "R1";
    if (r[6])                 return "R9";
    if (x || e)               return "R8";
    if (m == 2'b11)           return "R7";
    case (r[10:8])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare();
    resp_t act;
    act = {rsp_valid, rsp_paddr, rsp_seg, rsp_mapped, rsp_cached, rsp_fault, rsp_exc_code};
    checks++;
    if (act !== exp_q) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", exp_tag, act, exp_q);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic st,
                      input logic [1:0] m, input logic x, input logic e);
    @(negedge clk);
    compare();
    req_valid = v; req_vaddr = a; req_store = st;
    req_mode = m; req_exl = x; req_erl = e;
    exp_q = model(v, a, st, m, x, e);
    exp_tag = tag_of(exp_q, m, x, e);
    if (m == 2'b10 && exp_q[43] && !exp_q[6] && exp_q[10:8] == 3'd0) exp_tag = "R7";
    if (exp_q[43] && exp_q[7] && !exp_q[8]) exp_tag = "R10";
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [31:0] edges [10] = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h9FFF_FFFF, 32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000,
    32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF};

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    compare();
    @(negedge clk);
    rst = 1'b0;
    // Every segment edge against every mode, both directions
    for (int i = 0; i < 10; i++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          step(1'b1, edges[i], 1'(s), 2'(m), 1'b0, 1'b0);
    // R8: level overrides with user/supervisor mode field
    for (int i = 0; i < 10; i++) begin
      step(1'b1, edges[i], 1'b1, 2'b10, 1'b1, 1'b0);
      step(1'b1, edges[i], 1'b0, 2'b01, 1'b0, 1'b1);
      step(1'b1, edges[i], 1'b0, 2'b11, 1'b1, 1'b1);
    end
    // R1: bubbles carry junk inputs
    step(1'b0, 32'h8123_4567, 1'b1, 2'b00, 1'b0, 1'b0);
    step(1'b1, 32'h8123_4567, 1'b0, 2'b00, 1'b0, 1'b0);
    step(1'b0, 32'hF000_0000, 1'b1, 2'b10, 1'b0, 1'b0);
    // Random traffic
    for (int k = 0; k < 400; k++)
      step(1'($urandom), $urandom, 1'($urandom), 2'($urandom),
           ($urandom % 8) == 0, ($urandom % 8) == 0);
    // R11: reset after traffic clears outputs
    step(1'b1, 32'hA000_1000, 1'b0, 2'b00, 1'b0, 1'b0);
    @(negedge clk);
    compare();
    rst = 1'b1;
    exp_q = '0;
    exp_tag = "R11";
    @(negedge clk);
    compare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule